// File: doc/BRIEF.md
# Disk sector buffer pacing sequencer

This block paces the sector-by-sector exchange between a host DMA engine and one track of a disk. It does not hold sector data. It keeps a sector counter and a block selector for the two blocks of a track, and it raises the status flags the host polls: data request, correction transfer, buffer interrupt, buffer error and mechanism interrupt. It also drives a single interrupt line. Each block holds 85 data sectors and 4 correction sectors, followed by one gap sector.

The host programs the sequencer through a 32-bit control write. That write picks the starting block, can request a chained second block, holds or releases a sequencer reset, and starts a run. Each completed host DMA of a sector or correction buffer moves the sequence on by one step. In read mode the sequencer hands out data sectors, then correction sectors, then reaches the gap. In write mode it takes one priming step and then commits each sector one step late. On every delivered or committed sector a one-cycle strobe reports the block and sector index, so the data path can move the bytes.

Top module: `sector_pacer`

## Requirements
- R1: In a control write, bits 23:16 carry the start sector. 0x00 selects block 0 and 0x5A selects block 1, and both clear the sector counter. Any other value raises `misaligned` and leaves the block and counter unchanged. `misaligned` is re-evaluated on every control write.
- R2: Control bit 25 sets the chain-pending flag (buffer status bit 24). Control bit 24 clears the mechanism-interrupt flag (status bit 25), which `mech_cmd` sets.
- R3: Control bit 31 sets the running flag (buffer status bit 31) and performs one sequencing step in the same write.
- R4: While control bit 28 is held, the sequencer takes no step. The first control write with bit 28 clear releases it. The release clears status bits 30, 28, 27 and 26, the whole buffer status word, the sector counter and the block selector.
- R5: In read mode, a step at counter 0..84 strobes `fetch_stb` with index equal to the counter, increments the counter and sets data request (status bit 30).
- R6: In read mode, steps at counter 85..88 increment the counter. Correction transfer (status bit 28) is set when the counter reaches 89.
- R7: In read mode, a step at counter 89 does one of two things. With chain pending, it toggles the block, sets the counter to 0 and clears chain pending. Otherwise it clears the running flag.
- R8: In write mode, the step at counter 0 only moves the counter to 1 and sets data request. Steps at 1..84 strobe `commit_stb` with index counter-1, increment the counter and set data request. The step at 85 commits index 84 and then takes one of two paths. With chain pending it toggles the block, sets the counter to 1 and sets data request. Otherwise it moves the counter to 86 and stops.
- R9: Every step taken while running sets the buffer interrupt (status bit 26) and asserts `irq`. A step taken while not running changes nothing.
- R10: A status read while the buffer interrupt is set and the counter exceeds 85 clears that interrupt and performs the next step. Otherwise a status read has no effect.
- R11: A read-mode step on track 6 in block 0 clears data request and leaves the counter unchanged, with no fetch.
- R12: `irq` is high exactly when the buffer interrupt or the mechanism interrupt is pending. A control write that leaves neither pending deasserts it.
- R13: A running step beyond the last valid counter value (above 89 in read mode, above 85 in write mode) sets buffer error (status bit 27, buffer status bit 26) and leaves the counter unchanged.
- R14: `sel_data` clears data request and the buffer interrupt. `sel_corr` clears correction transfer and the buffer interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seek_we | input | 1 | Seek command strobe; latches mode and track |
| seek_write | input | 1 | 1 selects write mode, 0 read mode |
| seek_track | input | 12 | Track number of the seek |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 32 | Control write data |
| mech_cmd | input | 1 | Mechanism command completed; sets mechanism interrupt |
| xfer_done | input | 1 | Host DMA of a sector or correction buffer completed |
| sel_data | input | 1 | Host selected the sector buffer for DMA |
| sel_corr | input | 1 | Host selected the correction buffer for DMA |
| stat_rd | input | 1 | Host read of the status word |
| status | output | 32 | Status flags |
| buf_status | output | 32 | Buffer status flags |
| cur_block | output | 1 | Current block selector |
| cur_sector | output | 8 | Sector counter |
| commit_stb | output | 1 | Write-mode sector commit strobe |
| fetch_stb | output | 1 | Read-mode sector delivery strobe |
| xfer_idx | output | 8 | Sector index for the strobe |
| xfer_blk | output | 1 | Block for the strobe |
| misaligned | output | 1 | Last control write had an invalid start sector |
| irq | output | 1 | Interrupt line |

## Verification
The hardest state to reach from the ports is the buffer-error overrun. A correct host never steps past the end. The bench reaches it in two stages. It first finishes a full write block so that the counter rests at 86. It then issues a start write whose start sector is misaligned, which leaves the counter untouched while setting the running flag and stepping. The gap-sector auto-step on a status read and the chained block switch both need a full 89-step sweep first, so the bench walks every counter value in both modes. At each value it compares the strobes, the index and the counter with values computed from the step number.

// File: rtl/sp_pkg.sv
package sp_pkg;
  // status word bit positions
  localparam int ST_DREQ = 30;
  localparam int ST_CORR = 28;
  localparam int ST_ERR  = 27;
  localparam int ST_BINT = 26;
  localparam int ST_MINT = 25;
  // buffer status bit positions
  localparam int BS_RUN   = 31;
  localparam int BS_ERR   = 26;
  localparam int BS_CHAIN = 24;
  // control word bit positions
  localparam int CT_GO    = 31;
  localparam int CT_HOLD  = 28;
  localparam int CT_CHAIN = 25;
  localparam int CT_MCLR  = 24;

  typedef struct packed {
    logic go;
    logic hold;
    logic chain;
    logic mclr;
    logic pick_b0;
    logic pick_b1;
    logic misal;
  } ctrl_t;
endpackage

// File: rtl/sp_ctrl_decode.sv
module sp_ctrl_decode
  import sp_pkg::*;
#(
  parameter int B1_START = 8'h5A
) (
  input  logic [31:0] wdata,
  output ctrl_t       c
);
  logic [7:0] start;
  assign start = wdata[23:16];

  always_comb begin
    c.go      = wdata[CT_GO];
    c.hold    = wdata[CT_HOLD];
    c.chain   = wdata[CT_CHAIN];
    c.mclr    = wdata[CT_MCLR];
    c.pick_b0 = (start == 8'h00);
    c.pick_b1 = (start == 8'(B1_START));
    c.misal   = !(c.pick_b0 || c.pick_b1);
  end
endmodule

// File: rtl/sp_step.sv
module sp_step #(
  parameter int DATA_SECS  = 85,
  parameter int CORR_SECS  = 4,
  parameter int CNT_W      = 8,
  parameter int TRK_W      = 12,
  parameter int GATE_TRACK = 6
) (
  input  logic             wr_mode,
  input  logic [TRK_W-1:0] trk,
  input  logic             blk,
  input  logic [CNT_W-1:0] cnt,
  input  logic             pend,
  output logic             n_blk,
  output logic [CNT_W-1:0] n_cnt,
  output logic             n_pend,
  output logic             stop,
  output logic             dreq_set,
  output logic             dreq_clr,
  output logic             corr_set,
  output logic             err_set,
  output logic             commit,
  output logic             fetch,
  output logic [CNT_W-1:0] idx
);
  localparam logic [CNT_W-1:0] L_DATA = CNT_W'(DATA_SECS);
  localparam logic [CNT_W-1:0] L_GAP  = CNT_W'(DATA_SECS + CORR_SECS);
  localparam logic [TRK_W-1:0] L_GATE = TRK_W'(GATE_TRACK);

  always_comb begin
    n_blk = blk; n_cnt = cnt; n_pend = pend; stop = 1'b0;
    dreq_set = 1'b0; dreq_clr = 1'b0; corr_set = 1'b0; err_set = 1'b0;
    commit = 1'b0; fetch = 1'b0; idx = '0;
    if (wr_mode) begin
      if (cnt == '0) begin
        n_cnt = CNT_W'(1);
        dreq_set = 1'b1;
      end else if (cnt <= L_DATA) begin
        commit = 1'b1;
        idx = cnt - CNT_W'(1);
        if (cnt < L_DATA) begin
          n_cnt = cnt + CNT_W'(1);
          dreq_set = 1'b1;
        end else if (pend) begin
          n_blk = ~blk; n_cnt = CNT_W'(1); n_pend = 1'b0;
          dreq_set = 1'b1;
        end else begin
          n_cnt = cnt + CNT_W'(1);
          stop = 1'b1;
        end
      end else begin
        err_set = 1'b1;
      end
    end else begin
      if (trk == L_GATE && !blk) begin
        dreq_clr = 1'b1;
      end else if (cnt < L_DATA) begin
        fetch = 1'b1; idx = cnt;
        n_cnt = cnt + CNT_W'(1);
        dreq_set = 1'b1;
      end else if (cnt < L_GAP) begin
        n_cnt = cnt + CNT_W'(1);
        corr_set = (n_cnt == L_GAP);
      end else if (cnt == L_GAP) begin
        if (pend) begin
          n_blk = ~blk; n_cnt = '0; n_pend = 1'b0;
        end else begin
          stop = 1'b1;
        end
      end else begin
        err_set = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sector_pacer.sv
module sector_pacer
  import sp_pkg::*;
#(
  parameter int DATA_SECS  = 85,
  parameter int CORR_SECS  = 4,
  parameter int CNT_W      = 8,
  parameter int TRK_W      = 12,
  parameter int GATE_TRACK = 6,
  parameter int B1_START   = 8'h5A
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             seek_we,
  input  logic             seek_write,
  input  logic [TRK_W-1:0] seek_track,
  input  logic             ctrl_we,
  input  logic [31:0]      ctrl_wdata,
  input  logic             mech_cmd,
  input  logic             xfer_done,
  input  logic             sel_data,
  input  logic             sel_corr,
  input  logic             stat_rd,
  output logic [31:0]      status,
  output logic [31:0]      buf_status,
  output logic             cur_block,
  output logic [CNT_W-1:0] cur_sector,
  output logic             commit_stb,
  output logic             fetch_stb,
  output logic [CNT_W-1:0] xfer_idx,
  output logic             xfer_blk,
  output logic             misaligned,
  output logic             irq
);
  localparam logic [CNT_W-1:0] L_DATA = CNT_W'(DATA_SECS);
  localparam logic [CNT_W-1:0] L_GAP  = CNT_W'(DATA_SECS + CORR_SECS);

  // state
  logic             mode_wr, blk, run, pend, held;
  logic             dreq, corr, err, bint, mint, misal;
  logic [TRK_W-1:0] trk;
  logic [CNT_W-1:0] cnt;
  logic             cstb, fstb, sblk, irq_q;
  logic [CNT_W-1:0] sidx;

  ctrl_t c;
  sp_ctrl_decode #(.B1_START(B1_START)) u_dec (.wdata(ctrl_wdata), .c(c));

  // pre-step state after seek, selection, mechanism and control effects
  logic             p_mode, p_blk, p_run, p_pend, p_held;
  logic             p_dreq, p_corr, p_err, p_bint, p_mint, p_misal, do_step;
  logic [TRK_W-1:0] p_trk;
  logic [CNT_W-1:0] p_cnt;

  always_comb begin
    p_mode = mode_wr; p_trk = trk; p_blk = blk; p_cnt = cnt;
    p_run = run; p_pend = pend; p_held = held; p_dreq = dreq;
    p_corr = corr; p_err = err; p_bint = bint; p_mint = mint;
    p_misal = misal; do_step = 1'b0;
    if (seek_we) begin
      p_mode = seek_write; p_trk = seek_track;
    end
    if (sel_data) begin p_dreq = 1'b0; p_bint = 1'b0; end
    if (sel_corr) begin p_corr = 1'b0; p_bint = 1'b0; end
    if (mech_cmd) p_mint = 1'b1;
    if (ctrl_we) begin
      if (c.pick_b0) begin p_blk = 1'b0; p_cnt = '0; end
      if (c.pick_b1) begin p_blk = 1'b1; p_cnt = '0; end
      p_misal = c.misal;
      if (c.chain) p_pend = 1'b1;
      if (c.mclr)  p_mint = 1'b0;
      if (c.hold) begin
        p_held = 1'b1;
      end else if (held) begin
        p_held = 1'b0;
        p_bint = 1'b0; p_err = 1'b0; p_dreq = 1'b0; p_corr = 1'b0;
        p_run = 1'b0; p_pend = 1'b0; p_cnt = '0; p_blk = 1'b0;
      end
      if (c.go && !p_held) begin
        p_run = 1'b1; do_step = 1'b1;
      end
    end else if (xfer_done) begin
      do_step = !held;
    end else if (stat_rd && bint && cnt > L_DATA && !held) begin
      p_bint = 1'b0; do_step = 1'b1;
    end
  end

  logic             s_blk, s_pend, s_stop, s_dset, s_dclr, s_cset, s_eset, s_com, s_fet;
  logic [CNT_W-1:0] s_cnt, s_idx;

  sp_step #(.DATA_SECS(DATA_SECS), .CORR_SECS(CORR_SECS), .CNT_W(CNT_W),
            .TRK_W(TRK_W), .GATE_TRACK(GATE_TRACK)) u_step (
    .wr_mode(p_mode), .trk(p_trk), .blk(p_blk), .cnt(p_cnt), .pend(p_pend),
    .n_blk(s_blk), .n_cnt(s_cnt), .n_pend(s_pend), .stop(s_stop),
    .dreq_set(s_dset), .dreq_clr(s_dclr), .corr_set(s_cset), .err_set(s_eset),
    .commit(s_com), .fetch(s_fet), .idx(s_idx)
  );

  logic act;
  assign act = do_step && p_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_wr <= 1'b0; trk <= '0; blk <= 1'b0; cnt <= '0; run <= 1'b0;
      pend <= 1'b0; held <= 1'b0; dreq <= 1'b0; corr <= 1'b0; err <= 1'b0;
      bint <= 1'b0; mint <= 1'b0; misal <= 1'b0; cstb <= 1'b0; fstb <= 1'b0;
      sidx <= '0; sblk <= 1'b0; irq_q <= 1'b0;
    end else begin
      mode_wr <= p_mode; trk <= p_trk; held <= p_held; mint <= p_mint;
      misal <= p_misal;
      blk  <= act ? s_blk  : p_blk;
      cnt  <= act ? s_cnt  : p_cnt;
      pend <= act ? s_pend : p_pend;
      run  <= p_run && !(act && s_stop);
      dreq <= act ? ((p_dreq || s_dset) && !s_dclr) : p_dreq;
      corr <= p_corr || (act && s_cset);
      err  <= p_err  || (act && s_eset);
      bint <= p_bint || act;
      irq_q <= p_bint || act || p_mint;
      cstb <= act && s_com;
      fstb <= act && s_fet;
      if (act && (s_com || s_fet)) begin
        sidx <= s_idx; sblk <= p_blk;
      end
    end
  end

  always_comb begin
    status = '0;
    status[ST_DREQ] = dreq; status[ST_CORR] = corr; status[ST_ERR] = err;
    status[ST_BINT] = bint; status[ST_MINT] = mint;
    buf_status = '0;
    buf_status[BS_RUN] = run; buf_status[BS_ERR] = err; buf_status[BS_CHAIN] = pend;
  end

  assign cur_block  = blk;
  assign cur_sector = cnt;
  assign commit_stb = cstb;
  assign fetch_stb  = fstb;
  assign xfer_idx   = sidx;
  assign xfer_blk   = sblk;
  assign misaligned = misal;
  assign irq        = irq_q;

  // assertions
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= L_GAP);  // R13
  AST_STEP_INT: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && !ctrl_we && run && !held) |=> (bint && irq));  // R9
  AST_IDLE_STEP: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && !ctrl_we && !run && !seek_we) |=> $stable(cnt));  // R9
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (held && xfer_done && !ctrl_we) |=> $stable(cnt));  // R4
  AST_CORR_AT_END: assert property (@(posedge clk) disable iff (rst)
    $rose(corr) |-> (cnt == L_GAP));  // R6
  AST_COMMIT_MODE: assert property (@(posedge clk) disable iff (rst)
    commit_stb |-> (mode_wr && !fetch_stb));  // R8
endmodule

// File: tb/tb_sector_pacer.sv
module tb_sector_pacer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst = 1'b1;
  logic        seek_we = 0, seek_write = 0, ctrl_we = 0, mech_cmd = 0;
  logic        xfer_done = 0, sel_data = 0, sel_corr = 0, stat_rd = 0;
  logic [11:0] seek_track = '0;
  logic [31:0] ctrl_wdata = '0;
  logic [31:0] status, buf_status;
  logic        cur_block, commit_stb, fetch_stb, xfer_blk, misaligned, irq;
  logic [7:0]  cur_sector, xfer_idx;

  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sector_pacer dut (
    .clk(clk), .rst(rst), .seek_we(seek_we), .seek_write(seek_write),
    .seek_track(seek_track), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .mech_cmd(mech_cmd), .xfer_done(xfer_done), .sel_data(sel_data),
    .sel_corr(sel_corr), .stat_rd(stat_rd), .status(status),
    .buf_status(buf_status), .cur_block(cur_block), .cur_sector(cur_sector),
    .commit_stb(commit_stb), .fetch_stb(fetch_stb), .xfer_idx(xfer_idx),
    .xfer_blk(xfer_blk), .misaligned(misaligned), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic seek(input logic wr, input int t);
    @(negedge clk); seek_we = 1; seek_write = wr; seek_track = 12'(t);
    @(negedge clk); seek_we = 0;
  endtask
  task automatic ctrl(input logic [31:0] w);
    @(negedge clk); ctrl_we = 1; ctrl_wdata = w;
    @(negedge clk); ctrl_we = 0;
  endtask
  task automatic xfer();
    @(negedge clk); xfer_done = 1;
    @(negedge clk); xfer_done = 0;
  endtask
  task automatic srd();
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
  endtask
  task automatic mech();
    @(negedge clk); mech_cmd = 1;
    @(negedge clk); mech_cmd = 0;
  endtask
  task automatic seld();
    @(negedge clk); sel_data = 1;
    @(negedge clk); sel_data = 0;
  endtask
  task automatic selc();
    @(negedge clk); sel_corr = 1;
    @(negedge clk); sel_corr = 0;
  endtask
  task automatic bm_reset();
    ctrl(32'h1000_0000);
    ctrl(32'h0000_0000);
  endtask

  localparam logic [31:0] GO = 32'h8000_0000, CHAIN = 32'h0200_0000;

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("reset status", status, 32'h0);
    chk("reset buf_status", buf_status, 32'h0);
    chk("reset sector", {23'b0, cur_block, cur_sector}, 32'h0);
    chk("reset irq", irq, 0);

    // R9: step while idle does nothing
    xfer();
    chk("R9 idle step sector", cur_sector, 0);
    chk("R9 idle step status", status, 0);
    chk("R9 idle irq", irq, 0);

    // read sweep, one block, track 10
    seek(0, 10);
    ctrl(GO);
    chk("R3 run flag", buf_status[31], 1);
    chk("R5 first fetch", {fetch_stb, xfer_idx}, {1'b1, 8'd0});
    chk("R5 dreq", status[30], 1);
    chk("R9 bint/irq", {status[26], irq}, 2'b11);
    srd();
    chk("R10 no auto step below gap", cur_sector, 1);
    chk("R10 bint kept", status[26], 1);
    seld();
    chk("R14 sel_data clears", {status[30], status[26]}, 2'b00);
    chk("R12 irq low", irq, 0);
    for (int k = 1; k < 85; k++) begin
      xfer();
      chk("R5 read fetch", {fetch_stb, xfer_blk, xfer_idx, cur_sector},
          {1'b1, 1'b0, 8'(k), 8'(k + 1)});
    end
    for (int k = 85; k < 89; k++) begin
      xfer();
      chk("R6 corr sectors", {fetch_stb, cur_sector, status[28]},
          {1'b0, 8'(k + 1), (k == 88)});
    end
    srd();
    chk("R10 R7 gap stop", {buf_status[31], cur_sector}, {1'b0, 8'd89});
    chk("R9 gap bint", status[26], 1);
    selc();
    chk("R14 sel_corr clears", {status[28], status[26], irq}, 3'b000);

    // chained read from block 0
    ctrl(GO | CHAIN);
    chk("R2 chain flag", buf_status[24], 1);
    for (int k = 1; k < 89; k++) xfer();
    chk("R6 at gap", cur_sector, 89);
    xfer();
    chk("R7 chain switch", {cur_block, cur_sector, buf_status[31], buf_status[24]},
        {1'b1, 8'd0, 1'b1, 1'b0});
    xfer();
    chk("R7 block1 fetch", {fetch_stb, xfer_blk, xfer_idx}, {1'b1, 1'b1, 8'd0});

    // R1 start in block 1 and misaligned start
    bm_reset();
    ctrl(32'h005A_0000);
    chk("R1 pick block1", {cur_block, cur_sector, misaligned}, {1'b1, 8'd0, 1'b0});
    ctrl(32'h0013_0000);
    chk("R1 misaligned", {cur_block, misaligned}, 2'b11);

    // R4 hold and release
    ctrl(32'h1000_0000 | GO);
    chk("R4 go ignored while held", buf_status[31], 0);
    xfer();
    chk("R4 hold freezes", cur_sector, 0);
    ctrl(32'h0000_0000);
    chk("R4 release status", status & 32'h5C00_0000, 0);
    chk("R4 release buf", buf_status, 0);
    chk("R4 release sector", {cur_block, cur_sector}, 0);

    // R11 track 6 gating
    seek(0, 6);
    ctrl(GO);
    chk("R11 track6 block0", {fetch_stb, cur_sector, status[30], status[26]},
        {1'b0, 8'd0, 1'b0, 1'b1});
    ctrl(32'h005A_0000 | GO);
    chk("R11 track6 block1", {fetch_stb, cur_sector}, {1'b1, 8'd1});

    // write sweep, one block
    bm_reset();
    seek(1, 100);
    ctrl(GO);
    chk("R8 prime", {commit_stb, cur_sector, status[30]}, {1'b0, 8'd1, 1'b1});
    for (int k = 1; k < 85; k++) begin
      xfer();
      chk("R8 commit", {commit_stb, xfer_idx, cur_sector}, {1'b1, 8'(k - 1), 8'(k + 1)});
    end
    xfer();
    chk("R8 last commit stop", {commit_stb, xfer_idx, cur_sector, buf_status[31]},
        {1'b1, 8'd84, 8'd86, 1'b0});

    // R13 overrun: misaligned start keeps counter at 86
    ctrl(32'h0010_0000 | GO);
    chk("R13 error flags", {status[27], buf_status[26], misaligned}, 3'b111);
    chk("R13 no wrap", cur_sector, 86);

    // chained write
    bm_reset();
    ctrl(GO | CHAIN);
    for (int k = 1; k < 85; k++) xfer();
    xfer();
    chk("R8 chain write", {commit_stb, xfer_blk, xfer_idx, cur_block, cur_sector, status[30]},
        {1'b1, 1'b0, 8'd84, 1'b1, 8'd1, 1'b1});
    xfer();
    chk("R8 block1 commit", {commit_stb, xfer_blk, xfer_idx}, {1'b1, 1'b1, 8'd0});

    // R2 / R12 mechanism interrupt
    bm_reset();
    mech();
    chk("R2 mech set", {status[25], irq}, 2'b11);
    ctrl(32'h0100_0000);
    chk("R12 mech clr drops irq", {status[25], irq}, 2'b00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule